// File: doc/BRIEF.md
# Four-Word FIFO Write Serializer

This block sits between a producer that presents four 16-bit words at once, refreshed on each rising edge of a slow data clock, and the write port of a FIFO clocked by a faster write clock. The data clock is treated as an ordinary signal and is observed from inside the write-clock domain. Once a rising edge is seen there, all four words are copied into a holding register. The block then issues four write requests in order: word 0, word 1, word 2, word 3. A raised FIFO full flag pauses the sequence on the current word.

A small state machine controls the work. It has two states. In `ST_IDLE` no group is in progress. In `ST_SEND` a group is being written. The transition `ST_IDLE -> ST_SEND` ("capture") happens on a detected data-clock rising edge. The state stays in `ST_SEND`, with the word index advancing, on each accepted write. The transition `ST_SEND -> ST_SEND` with the index held ("stall") happens while the full flag is high. The transition `ST_SEND -> ST_IDLE` ("release") happens when the fourth word is accepted. A data-clock edge that arrives during `ST_SEND` does not start a group and sets a sticky overrun flag. The write clock should run at least four times faster than the data clock, with extra margin for synchronizer delay and any stalls.

Top module: `quad_word_serializer`

## Requirements
- R1: While `rst` is high at a write-clock edge, `wr_req`, `busy` and `overrun` are 0 after that edge, and the word index returns to word 0.
- R2: If `data_clk` rises between two write-clock edges while the block is idle, `wr_req` stays 0 after the first and second following edges and is 1 after the third.
- R3: While `wr_req` is 1, `wr_data` carries the captured words in the order `in_w0`, `in_w1`, `in_w2`, `in_w3`. It moves to the next word only after a cycle in which the write was accepted (`wr_req`=1 and `fifo_full`=0).
- R4: Each group produces exactly four accepted writes. With `fifo_full` held at 0, `wr_req` is 1 for exactly four consecutive cycles and then 0.
- R5: During a cycle with `wr_req`=1 and `fifo_full`=1, the write is not accepted. The same word is presented again in the next cycle with `wr_req` still 1.
- R6: `busy` is 1 from the cycle in which `wr_req` first rises for a group until the fourth write is accepted. It equals `wr_req` at all times.
- R7: Changes on `in_w0`..`in_w3` after the capture edge do not affect the words written for the current group.
- R8: A rising edge of `data_clk` that is detected while `busy`=1 sets `overrun` to 1. That edge starts no group, so `wr_req` stays 0 after the current group ends. `overrun` stays 0 while every edge arrives with the block idle.
- R9: A falling edge of `data_clk` starts no group.
- R10: Once set, `overrun` stays 1 until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | FIFO write clock |
| rst | input | 1 | Synchronous active-high reset |
| data_clk | input | 1 | Slow data clock from the producer, asynchronous to `clk_wr` |
| in_w0 | input | 16 | Word written first |
| in_w1 | input | 16 | Word written second |
| in_w2 | input | 16 | Word written third |
| in_w3 | input | 16 | Word written fourth |
| fifo_full | input | 1 | FIFO full flag; high blocks acceptance |
| wr_data | output | 16 | FIFO write data |
| wr_req | output | 1 | FIFO write request |
| busy | output | 1 | A group is being written |
| overrun | output | 1 | Sticky: an edge arrived while busy |

## Verification
Faults show up at the ports quickly:
- A wrong word index appears on `wr_data` in the same cycle as a misordered or repeated word.
- An index that advances during a stall shows as a skipped word in the cycle after the full flag was high.
- A state register that fails to release shows as a fifth cycle of `wr_req`.
- A mistake in synchronizer depth or edge detection moves the first `wr_req` away from the third write-clock edge, or triggers a group on the falling edge within three cycles.
- A holding register that follows the inputs instead of the capture shows the altered input values on `wr_data` in the next accepted word.

The sweep covers every 8-bit stall pattern, so each index is exercised under each stall combination.

// File: rtl/qws_pkg.sv
package qws_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } qws_state_e;
endpackage

// File: rtl/qws_edge_sync.sv
module qws_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-1:0], async_in};
    end

    assign rise = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/qws_hold_mux.sv
module qws_hold_mux #(
    parameter int W = 16,
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [N*W-1:0] in_words,
    input  logic [IW-1:0]  sel,
    output logic [W-1:0]   out_word
);
    logic [W-1:0] hold_q [N];

    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (load) hold_q[i] <= in_words[i*W +: W];
        end

        AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
            !load |=> $stable(hold_q[i])); // R7
    end

    assign out_word = hold_q[sel];
endmodule

// File: rtl/qws_ctrl.sv
module qws_ctrl #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          fifo_full,
    output logic          load,
    output logic [IW-1:0] sel,
    output logic          wr_req,
    output logic          busy,
    output logic          overrun
);
    import qws_pkg::*;

    qws_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          ovr_q;
    logic          last;

    assign last = (idx_q == IW'(N-1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) begin          // capture
                    state_d = ST_SEND;
                    idx_d   = '0;
                end
            end
            ST_SEND: begin
                if (!fifo_full) begin
                    if (last) begin      // release
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin       // advance
                        idx_d = idx_q + 1'b1;
                    end
                end                      // stall otherwise
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (rise && state_q == ST_SEND) ovr_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        load    = (state_q == ST_IDLE) && rise;
        sel     = idx_q;
        wr_req  = (state_q == ST_SEND);
        busy    = (state_q == ST_SEND);
        overrun = ovr_q;
    end

    AST_START_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        (rise && !busy) |=> (wr_req && sel == '0)); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && fifo_full) |=> (wr_req && $stable(sel))); // R5
    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !fifo_full && sel == IW'(N-1)) |=> !wr_req); // R4
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (rise && busy) |=> overrun); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10
endmodule

// File: rtl/quad_word_serializer.sv
module quad_word_serializer #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_wr,
    input  logic         rst,
    input  logic         data_clk,
    input  logic [W-1:0] in_w0,
    input  logic [W-1:0] in_w1,
    input  logic [W-1:0] in_w2,
    input  logic [W-1:0] in_w3,
    input  logic         fifo_full,
    output logic [W-1:0] wr_data,
    output logic         wr_req,
    output logic         busy,
    output logic         overrun
);
    localparam int N  = 4;
    localparam int IW = $clog2(N);

    logic          rise;
    logic          load;
    logic [IW-1:0] sel;

    qws_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_wr),
        .rst      (rst),
        .async_in (data_clk),
        .rise     (rise)
    );

    qws_ctrl #(.N(N)) u_ctrl (
        .clk       (clk_wr),
        .rst       (rst),
        .rise      (rise),
        .fifo_full (fifo_full),
        .load      (load),
        .sel       (sel),
        .wr_req    (wr_req),
        .busy      (busy),
        .overrun   (overrun)
    );

    qws_hold_mux #(.W(W), .N(N)) u_hold (
        .clk      (clk_wr),
        .rst      (rst),
        .load     (load),
        .in_words ({in_w3, in_w2, in_w1, in_w0}),
        .sel      (sel),
        .out_word (wr_data)
    );
endmodule

// File: tb/quad_word_serializer_tb_top.sv
`timescale 1ns/1ps
module quad_word_serializer_tb_top;
    logic        clk_wr = 1'b0;
    logic        rst = 1'b1;
    logic        data_clk = 1'b0;
    logic [15:0] in_w0 = '0, in_w1 = '0, in_w2 = '0, in_w3 = '0;
    logic        fifo_full = 1'b0;
    logic [15:0] wr_data;
    logic        wr_req, busy, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk_wr = ~clk_wr;

    quad_word_serializer dut_i (
        .clk_wr(clk_wr), .rst(rst), .data_clk(data_clk),
        .in_w0(in_w0), .in_w1(in_w1), .in_w2(in_w2), .in_w3(in_w3),
        .fifo_full(fifo_full), .wr_data(wr_data), .wr_req(wr_req),
        .busy(busy), .overrun(overrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk_wr);
        @(negedge clk_wr);
    endtask

    task automatic send_group(input logic [15:0] a, input logic [15:0] b,
                              input logic [15:0] c, input logic [15:0] d,
                              input logic [7:0] stall, input bit scramble);
        logic [15:0] e [4];
        int idx;
        int n;
        bit prev_full;
        e[0] = a; e[1] = b; e[2] = c; e[3] = d;
        in_w0 = a; in_w1 = b; in_w2 = c; in_w3 = d;
        data_clk = 1'b1;
        for (int k = 0; k < 2; k++) begin
            cyc();
            chk("R2", "wr_req before third edge", 32'(wr_req), 32'd0);
        end
        cyc();
        chk("R2", "wr_req at third edge", 32'(wr_req), 32'd1);
        chk("R6", "busy at start", 32'(busy), 32'd1);
        data_clk = 1'b0;                 // falling edge mid-group (R9)
        if (scramble) begin              // R7
            in_w0 = ~a; in_w1 = ~b; in_w2 = ~c; in_w3 = ~d;
        end
        idx = 0; n = 0; prev_full = 1'b0;
        while (idx < 4) begin
            chk(prev_full ? "R5" : "R3", "wr_data", 32'(wr_data), 32'(e[idx]));
            chk(prev_full ? "R5" : "R4", "wr_req active", 32'(wr_req), 32'd1);
            chk("R6", "busy tracks wr_req", 32'(busy), 32'(wr_req));
            fifo_full = (n < 8) ? stall[n] : 1'b0;
            prev_full = fifo_full;
            if (!fifo_full) idx++;
            n++;
            cyc();
        end
        fifo_full = 1'b0;
        chk("R4", "wr_req after fourth accept", 32'(wr_req), 32'd0);
        chk("R6", "busy after fourth accept", 32'(busy), 32'd0);
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R9", "no group after falling edge", 32'(wr_req), 32'd0);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk_wr);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] ov [4];
        int j;
        rst = 1'b1;
        repeat (3) cyc();
        chk("R1", "wr_req in reset", 32'(wr_req), 32'd0);
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        chk("R1", "overrun in reset", 32'(overrun), 32'd0);
        rst = 1'b0;
        cyc();

        for (int g = 0; g < 256; g++) begin
            send_group(16'(g * 4)     ^ 16'h1234,
                       16'(g * 4 + 1) ^ 16'h5A5A,
                       16'(g * 4 + 2) ^ 16'hC3C3,
                       16'(g * 4 + 3) ^ 16'hF00F,
                       8'(g), g[0]);
        end
        chk("R8", "no overrun when idle at every edge", 32'(overrun), 32'd0);

        // overrun: second edge while stalled
        ov[0] = 16'hAAAA; ov[1] = 16'hBBBB; ov[2] = 16'hCCCC; ov[3] = 16'hDDDD;
        in_w0 = ov[0]; in_w1 = ov[1]; in_w2 = ov[2]; in_w3 = ov[3];
        fifo_full = 1'b1;
        data_clk = 1'b1;
        repeat (3) cyc();
        chk("R2", "wr_req at third edge (stalled)", 32'(wr_req), 32'd1);
        data_clk = 1'b0;
        repeat (3) cyc();
        data_clk = 1'b1;
        in_w0 = 16'h0101; in_w1 = 16'h0202; in_w2 = 16'h0303; in_w3 = 16'h0404;
        repeat (4) cyc();
        chk("R8", "overrun set", 32'(overrun), 32'd1);
        chk("R8", "old group kept", 32'(wr_data), 32'(ov[0]));
        fifo_full = 1'b0;
        j = 0;
        while (j < 4) begin
            chk("R8", "old group word", 32'(wr_data), 32'(ov[j]));
            j++;
            cyc();
        end
        for (int k = 0; k < 6; k++) begin
            chk("R8", "no group from edge while busy", 32'(wr_req), 32'd0);
            cyc();
        end
        chk("R10", "overrun sticky", 32'(overrun), 32'd1);
        data_clk = 1'b0;
        repeat (3) cyc();
        chk("R10", "overrun still set", 32'(overrun), 32'd1);
        rst = 1'b1;
        cyc();
        chk("R1", "overrun cleared by reset", 32'(overrun), 32'd0);
        chk("R1", "wr_req cleared by reset", 32'(wr_req), 32'd0);
        rst = 1'b0;
        cyc();
        send_group(16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule